// File: doc/BRIEF.md
# Reciprocal Frequency Counter

This block measures the frequency of a sampled waveform by timing a whole number of its periods against the system clock, rather than counting periods inside a fixed gate. Each incoming sample is compared against two programmable thresholds with hysteresis, which gives a clean binary level even when the waveform is noisy near its crossing point. Rising transitions of that level mark period boundaries. The block counts clock cycles across 2^E consecutive periods, where E is a small exponent input, and publishes that count. Software then forms the frequency as 2^E times the clock rate (125 MHz), divided by the count.

The sample stream is forwarded unchanged to an output stream, so the counter can sit inline in front of other consumers. The first qualifying rising transition after reset only starts the timing. Each later closing transition ends one measurement and starts the next at the same instant, so no periods are lost between results. The cycle counter saturates rather than wrapping. A sticky flag records that a measurement ran past the counter's range.

Top module: `recip_freq_counter`

## Requirements
- R1: `m_tdata` and `m_tvalid` equal `s_tdata` and `s_tvalid` in the same cycle, with no register in between.
- R2: A valid sample strictly greater than `thr_hi` (signed) sets the internal level to 1. A valid sample strictly less than `thr_lo` clears it to 0. A sample between the thresholds, or equal to one of them, leaves the level unchanged. A 0-to-1 change of the level is a rising event.
- R3: A sample with `s_tvalid` low leaves the level unchanged, whatever its value. The clock-cycle count keeps advancing while samples are invalid.
- R4: Let rising events occur in clock cycles t0 and t1, with t1 being the 2^E-th event after t0, where E is `period_exp`. At t1, the value `t1 - t0` is written to `result`.
- R5: After reset, the first rising event only arms the counter and produces no result. Each closing event starts the next measurement in the same cycle.
- R6: `result_valid` is high for exactly the one cycle after the clock edge that updates `result`. `result` holds its value in every other cycle.
- R7: The cycle count saturates at 2^CNT_W-1. A measurement that closes after saturation reports all ones.
- R8: `overflow` goes high when an armed measurement is at its saturated count in a cycle that does not close it. It then stays high until reset.
- R9: Synchronous active-high `rst` clears `result`, `result_valid`, `overflow`, the level, the armed state and both counters.
- R10: With `period_exp` = 0, every rising event after the arming one closes a one-period measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | DATA_W | Signed sample (14-bit value sign-extended) |
| s_tvalid | input | 1 | Sample valid |
| m_tdata | output | DATA_W | Forwarded sample |
| m_tvalid | output | 1 | Forwarded valid |
| thr_hi | input | DATA_W | Signed upper threshold (sets level) |
| thr_lo | input | DATA_W | Signed lower threshold (clears level) |
| period_exp | input | EXP_W | Exponent E; periods per measurement = 2^E |
| result | output | CNT_W | Clock cycles spanned by the last 2^E periods |
| result_valid | output | 1 | One-cycle strobe on each result update |
| overflow | output | 1 | Sticky: a measurement exceeded the counter range |

## Verification
A wrong level bit shows up at the ports as an extra or a missing rising event. The very next result then reports roughly one period too many or too few, and every later result stays out of phase. A period counter that is off by one turns up in the first result after arming, as a count spanning 2^E+1 or 2^E-1 periods. A cycle counter error appears in the first result it feeds. Saturation and the sticky flag can only be seen after 2^CNT_W cycles, so the bench uses a narrow counter to reach that point within a few thousand cycles.

// File: rtl/recip_freq_counter.sv
module recip_freq_counter #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32,
  parameter int EXP_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [EXP_W-1:0]  period_exp,
  output logic [CNT_W-1:0]  result,
  output logic              result_valid,
  output logic              overflow
);
  localparam int PER_W = 1 << EXP_W;

  logic             lvl, lvl_n, armed, rise, close, cyc_full;
  logic [CNT_W-1:0] cyc;
  logic [PER_W-1:0] pc, tgt;

  assign m_tdata  = s_tdata;
  assign m_tvalid = s_tvalid;

  always_comb begin
    lvl_n = lvl;
    if (s_tvalid) begin
      if ($signed(s_tdata) > $signed(thr_hi))      lvl_n = 1'b1;
      else if ($signed(s_tdata) < $signed(thr_lo)) lvl_n = 1'b0;
    end
  end

  assign rise     = lvl_n & ~lvl;
  assign tgt      = PER_W'(1) << period_exp;
  assign close    = rise & armed & (pc == tgt - PER_W'(1));
  assign cyc_full = &cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl          <= 1'b0;
      armed        <= 1'b0;
      pc           <= '0;
      cyc          <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      overflow     <= 1'b0;
    end else begin
      lvl          <= lvl_n;
      result_valid <= close;
      if (close) result <= cyc;
      if (rise && (!armed || close)) begin
        armed <= 1'b1;
        pc    <= '0;
        cyc   <= CNT_W'(1);
      end else begin
        if (rise) pc <= pc + PER_W'(1);
        if (!cyc_full) cyc <= cyc + CNT_W'(1);
      end
      if (armed && cyc_full && !close) overflow <= 1'b1;
    end
  end

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(result));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  p_result_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (result != '0));
  p_valid_edge_r3: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(s_tvalid));
endmodule

// File: tb/recip_freq_counter_bench.sv
module recip_freq_counter_bench;
  localparam int CW   = 12;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic [15:0] s_tdata, thr_hi, thr_lo;
  logic s_tvalid;
  logic [15:0] m_tdata;
  logic m_tvalid;
  logic [4:0] period_exp;
  logic [CW-1:0] result;
  logic result_valid, overflow;

  recip_freq_counter #(.DATA_W(16), .CNT_W(CW), .EXP_W(5)) u_recip_freq_counter (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .period_exp(period_exp), .result(result), .result_valid(result_valid),
    .overflow(overflow));

  int checks = 0, errors = 0;
  bit m_lvl, m_armed, m_ovf, e_rv;
  int m_pc, m_cc, e_res;

  function automatic bit next_level(bit cur, int x, bit v, int hi, int lo);
    if (!v) return cur;
    if (x > hi) return 1'b1;
    if (x < lo) return 1'b0;
    return cur;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic compare_outputs();
    chk(result_valid == e_rv, "R6 result_valid", result_valid, e_rv);
    chk(result == CW'(e_res), "R4/R7 result", result, e_res);
    chk(overflow == m_ovf, "R8 overflow", overflow, m_ovf);
  endtask

  task automatic step(int x, bit v);
    bit nl, rise, cls, full;
    @(negedge clk);
    compare_outputs();
    s_tdata  = 16'(x);
    s_tvalid = v;
    #1;
    chk(m_tdata == 16'(x) && m_tvalid == v, "R1 passthrough", m_tdata, 16'(x));
    nl   = next_level(m_lvl, x, v, $signed(thr_hi), $signed(thr_lo));
    rise = nl & ~m_lvl;
    cls  = rise && m_armed && (m_pc == (1 << period_exp) - 1);
    full = (m_cc == MAXC);
    if (m_armed && full && !cls) m_ovf = 1'b1;
    e_rv = cls;
    if (cls) e_res = m_cc;
    if (rise && (!m_armed || cls)) begin
      m_armed = 1'b1; m_pc = 0; m_cc = 1;
    end else begin
      if (rise) m_pc++;
      if (!full) m_cc++;
    end
    m_lvl = nl;
  endtask

  task automatic do_reset(int exp_v, int hi, int lo);
    @(negedge clk);
    rst = 1'b1; s_tvalid = 1'b0; s_tdata = '0;
    period_exp = 5'(exp_v); thr_hi = 16'(hi); thr_lo = 16'(lo);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_lvl = 0; m_armed = 0; m_ovf = 0; e_rv = 0; m_pc = 0; m_cc = 0; e_res = 0;
    chk(result == '0 && !result_valid && !overflow, "R9 reset state", result, 0);
  endtask

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom_range(0, hi - lo));
  endfunction

  task automatic wave(int periods, int hmin, int hmax, bit gaps);
    int hi, lo;
    hi = $signed(thr_hi); lo = $signed(thr_lo);
    for (int p = 0; p < periods; p++) begin
      int hlen, llen;
      hlen = rnd(hmin, hmax); llen = rnd(hmin, hmax);
      for (int i = 0; i < hlen; i++) begin
        if (gaps && $urandom_range(0, 4) == 0) step(rnd(-8192, 8191), 1'b0);
        else if (i == 0) step(rnd(hi + 1, 8191), 1'b1);
        else step(rnd(lo, 8191), 1'b1);
      end
      for (int i = 0; i < llen; i++) begin
        if (gaps && $urandom_range(0, 4) == 0) step(rnd(-8192, 8191), 1'b0);
        else if (i == 0) step(rnd(-8192, lo - 1), 1'b1);
        else step(rnd(-8192, hi), 1'b1);
      end
    end
  endtask

  int pulses;
  always @(posedge clk) if (!rst && result_valid) pulses++;

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; s_tvalid = 1'b0; s_tdata = '0;
    pulses = 0;

    // R9, R10: one period per result, exact square wave of 10 cycles
    do_reset(0, 512, -512);
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 5; i++) step(1000, 1'b1);
      for (int i = 0; i < 5; i++) step(-1000, 1'b1);
    end
    chk(pulses == 5, "R5/R10 result count", pulses, 5);

    // R2: samples equal to thresholds hold the level
    do_reset(1, 512, -512);
    for (int p = 0; p < 5; p++) begin
      step(513, 1'b1); step(-512, 1'b1); step(512, 1'b1); step(-512, 1'b1);
      step(-513, 1'b1); step(512, 1'b1); step(-512, 1'b1);
    end

    // R3: invalid extreme samples ignored
    do_reset(0, 512, -512);
    for (int p = 0; p < 5; p++) begin
      step(2000, 1'b1); step(-8000, 1'b0); step(8000, 1'b0);
      step(-2000, 1'b1); step(8000, 1'b0); step(-2000, 1'b0);
    end

    // R2, R4: random waves, noise inside the band, varied exponents and thresholds
    for (int r = 0; r < 8; r++) begin
      int e, hi, lo;
      e  = rnd(0, 3);
      lo = rnd(-2000, 0);
      hi = rnd(lo, 2000);
      do_reset(e, hi, lo);
      wave(rnd(6, 20), 1, 12, 1'b1);
    end

    // R7, R8: saturation and sticky overflow
    do_reset(1, 512, -512);
    step(1000, 1'b1); step(-1000, 1'b1);
    for (int i = 0; i < MAXC + 20; i++) step(0, 1'b1);
    pulses = 0;
    for (int p = 0; p < 4; p++) begin
      step(1000, 1'b1); step(1000, 1'b1); step(-1000, 1'b1); step(-1000, 1'b1);
    end
    chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
    chk(pulses == 2, "R7 results after saturation", pulses, 2);
    step(0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule